// File: doc/BRIEF.md
# Load-Store Data Alignment Unit

This unit sits between a 64-bit integer register file and a byte-addressed memory port that is 64 bits wide. For each request it adds a sign-extended 16-bit offset to a base register value to form the effective address. It checks that the access is aligned to its own size. For a store it works out the byte-lane enables and moves the store value into the lanes it belongs in. For a load it pulls the addressed bytes out of the returned memory word and extends them to 64 bits.

A mode input selects the byte order for each request. In little-endian order the least significant byte of the value sits at the lowest address. In big-endian order the most significant byte sits there. An access that is not aligned to its own size is never split into two memory accesses. Instead, the unit raises a fault for that cycle and issues nothing to memory.

The request side is combinational. The load return side is registered. The unit keeps the size, lane offset, extension mode and byte order of the outstanding load, so it does not depend on the request inputs while the data is on its way back.

Top module: `lsa_unit`

## Requirements
- R1: The effective address is the base value plus the offset sign-extended to 64 bits. `mem_addr` carries that address with its three low bits cleared, which selects a doubleword.
- R2: When `base_idx` is 0, the base is taken as zero whatever `base_val` holds. This gives absolute addressing. Register-indirect access is a request with offset 0.
- R3: `req_size` encodes 0 as byte, 1 as halfword, 2 as word and 3 as doubleword, with n = 1, 2, 4 or 8 bytes. When `req_valid` is high and the effective address is not a multiple of n, `fault` is high in that same cycle and both `mem_we` and `mem_re` stay low.
- R4: An aligned store (`req_store`=1) drives `mem_we` high. `mem_be` bit k is set exactly for the lanes k from a to a+n-1, where a is the effective address modulo 8. Lane k is byte address `mem_addr`+k and is carried on data bits 8k+7..8k.
- R5: In little-endian mode (`big_endian`=0), store value byte i (byte 0 is the least significant) goes to lane a+i. Every lane that is not enabled carries zero on `mem_wdata`.
- R6: In big-endian mode (`big_endian`=1), store value byte i goes to lane a+n-1-i.
- R7: An aligned load (`req_store`=0) drives `mem_re` high, keeps `mem_we` low and sets `mem_be` to the same lane set as R4.
- R8: The load result takes value byte i from the lane given by the R5/R6 mapping, using the byte order in force when the load was issued. When `req_unsigned` was 0 at issue, bit 8n-1 of the gathered value is copied into all higher bits.
- R9: When `req_unsigned` was 1 at issue, the bits of the load result above bit 8n-1 are zero.
- R10: `ld_valid` is high, and `ld_result` holds the extended value, in the cycle after the cycle in which `rd_valid` is high. In any other cycle `ld_valid` is low.
- R11: After reset, `ld_valid` is low and `ld_result` is zero.
- R12: In a cycle with `req_valid` low, `mem_we`, `mem_re` and `fault` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | Access size code (R3) |
| req_unsigned | input | 1 | Load uses zero extension |
| big_endian | input | 1 | Byte order for this request |
| base_idx | input | 5 | Index of the base register; 0 means a zero base |
| base_val | input | 64 | Value read from the base register |
| offset | input | 16 | Signed address offset |
| st_data | input | 64 | Store value, right-justified |
| rd_valid | input | 1 | Read data is returned this cycle |
| rd_data | input | 64 | Memory word returned for the outstanding load |
| mem_addr | output | 64 | Doubleword-aligned memory address |
| mem_be | output | 8 | Byte-lane enables |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 64 | Lane-steered store data |
| fault | output | 1 | Misaligned access in this cycle |
| ld_valid | output | 1 | Load result valid |
| ld_result | output | 64 | Extended load value |

## Verification
The bench aims at halfwords and words whose lane offset is not zero, in both byte orders. A design that reversed the lane mapping in only one of the two orders would show swapped bytes there, which a byte or a doubleword at lane 0 would hide. It also sends misaligned requests of every multi-byte size, including a doubleword that is off by 4. If any size used the wrong alignment mask, that request would reach memory with a write or read strobe instead of a fault. Loads with the top data bit set are run with signed and with unsigned extension, and with the byte-order input flipped while the data is returned. A unit that did not hold its load context would then extend from the wrong bit or pick up the wrong lanes. Requests with a zero base index and a garbage base value, and requests with negative offsets, catch a base that was not forced to zero and an offset that was not sign-extended.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  localparam int DATA_W = 64;
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  // context kept for an outstanding load
  typedef struct packed {
    logic [LANE_W-1:0] lane_off;
    acc_size_e         size;
    logic              uns;
    logic              big;
  } ld_ctx_t;

  function automatic logic [3:0] size_bytes(acc_size_e s);
    return 4'd1 << s;
  endfunction

  function automatic logic misaligned(logic [LANE_W-1:0] lo, acc_size_e s);
    case (s)
      SZ_HALF: return lo[0];
      SZ_WORD: return |lo[1:0];
      SZ_DBL:  return |lo;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [LANES-1:0] lane_mask(logic [LANE_W-1:0] lo, acc_size_e s);
    logic [2*LANES-1:0] m;
    m = ((2*LANES)'(1) << size_bytes(s)) - (2*LANES)'(1);
    m = m << lo;
    return m[LANES-1:0];
  endfunction

  // lane that holds value byte i for the given order
  function automatic logic [LANE_W-1:0] value_lane(logic [LANE_W-1:0] lo, acc_size_e s,
                                                   logic [LANE_W-1:0] i, logic big);
    logic [LANE_W-1:0] last;
    last = LANE_W'(size_bytes(s) - 4'd1);
    return big ? LANE_W'(lo + last - i) : LANE_W'(lo + i);
  endfunction

  // value byte that a given lane carries (inverse of value_lane)
  function automatic logic [LANE_W-1:0] lane_value(logic [LANE_W-1:0] lo, acc_size_e s,
                                                   logic [LANE_W-1:0] k, logic big);
    logic [LANE_W-1:0] rel;
    logic [LANE_W-1:0] last;
    rel  = LANE_W'(k - lo);
    last = LANE_W'(size_bytes(s) - 4'd1);
    return big ? LANE_W'(last - rel) : rel;
  endfunction

  function automatic logic [DATA_W-1:0] extend(logic [DATA_W-1:0] g, acc_size_e s, logic uns);
    logic [DATA_W-1:0] keep;
    logic              sgn;
    case (s)
      SZ_BYTE: begin keep = 64'h0000_0000_0000_00FF; sgn = g[7];  end
      SZ_HALF: begin keep = 64'h0000_0000_0000_FFFF; sgn = g[15]; end
      SZ_WORD: begin keep = 64'h0000_0000_FFFF_FFFF; sgn = g[31]; end
      default: begin keep = '1;                      sgn = 1'b0;  end
    endcase
    return (g & keep) | ((sgn && !uns) ? ~keep : '0);
  endfunction

endpackage

// File: rtl/lsa_agen.sv
module lsa_agen
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 16,
  parameter int IDX_W  = 5
) (
  input  logic [IDX_W-1:0]  base_idx,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [OFF_W-1:0]  offset,
  input  acc_size_e         size,
  output logic [ADDR_W-1:0] ea,
  output logic              misalign
);

  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] base_eff;
  logic [ADDR_W-1:0] off_sx;

  always_comb begin
    base_eff = (base_idx == '0) ? '0 : base_val;
    off_sx   = {{EXT_W{offset[OFF_W-1]}}, offset};
    ea       = base_eff + off_sx;
    misalign = misaligned(ea[LANE_W-1:0], size);
  end

endmodule

// File: rtl/lsa_store_steer.sv
module lsa_store_steer
  import lsa_pkg::*;
(
  input  logic [LANE_W-1:0] lane_off,
  input  acc_size_e         size,
  input  logic              big,
  input  logic [DATA_W-1:0] data,
  output logic [LANES-1:0]  mask,
  output logic [DATA_W-1:0] wdata
);

  assign mask = lane_mask(lane_off, size);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] src;
    always_comb begin
      src = lane_value(lane_off, size, LANE_W'(k), big);
      wdata[8*k +: 8] = mask[k] ? data[{src, 3'b000} +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
  import lsa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  ld_ctx_t           ctx_in,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_result
);

  ld_ctx_t           ctx_q;
  logic [DATA_W-1:0] gathered;
  logic [3:0]        nbytes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctx_q <= '0;
    else if (capture) ctx_q <= ctx_in;
  end

  assign nbytes = size_bytes(ctx_q.size);

  for (genvar i = 0; i < LANES; i++) begin : g_byte
    logic [LANE_W-1:0] lane;
    always_comb begin
      lane = value_lane(ctx_q.lane_off, ctx_q.size, LANE_W'(i), ctx_q.big);
      gathered[8*i +: 8] = (4'(i) < nbytes) ? rd_data[{lane, 3'b000} +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_valid  <= 1'b0;
      ld_result <= '0;
    end else begin
      ld_valid <= rd_valid;
      if (rd_valid) ld_result <= extend(gathered, ctx_q.size, ctx_q.uns);
    end
  end

endmodule

// File: rtl/lsa_unit.sv
module lsa_unit
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 16,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_unsigned,
  input  logic              big_endian,
  input  logic [IDX_W-1:0]  base_idx,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [OFF_W-1:0]  offset,
  input  logic [63:0]       st_data,
  input  logic              rd_valid,
  input  logic [63:0]       rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_be,
  output logic              mem_we,
  output logic              mem_re,
  output logic [63:0]       mem_wdata,
  output logic              fault,
  output logic              ld_valid,
  output logic [63:0]       ld_result
);

  acc_size_e         size_e;
  logic [ADDR_W-1:0] ea;
  logic              agen_misalign;
  logic              issue_store;
  logic              issue_load;
  logic [LANES-1:0]  st_mask;
  logic [DATA_W-1:0] st_wdata;
  ld_ctx_t           ctx_new;

  assign size_e = acc_size_e'(req_size);

  lsa_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_agen (
    .base_idx (base_idx),
    .base_val (base_val),
    .offset   (offset),
    .size     (size_e),
    .ea       (ea),
    .misalign (agen_misalign)
  );

  lsa_store_steer u_steer (
    .lane_off (ea[LANE_W-1:0]),
    .size     (size_e),
    .big      (big_endian),
    .data     (st_data),
    .mask     (st_mask),
    .wdata    (st_wdata)
  );

  assign issue_store = req_valid &&  req_store && !agen_misalign;
  assign issue_load  = req_valid && !req_store && !agen_misalign;

  assign mem_addr  = {ea[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
  assign mem_be    = (issue_store || issue_load) ? st_mask : '0;
  assign mem_we    = issue_store;
  assign mem_re    = issue_load;
  assign mem_wdata = issue_store ? st_wdata : '0;
  assign fault     = req_valid && agen_misalign;

  always_comb begin
    ctx_new.lane_off = ea[LANE_W-1:0];
    ctx_new.size     = size_e;
    ctx_new.uns      = req_unsigned;
    ctx_new.big      = big_endian;
  end

  lsa_load_extract u_load (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (issue_load),
    .ctx_in    (ctx_new),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .ld_valid  (ld_valid),
    .ld_result (ld_result)
  );

endmodule

// File: rtl/lsa_unit_chk.sv
module lsa_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [1:0]  req_size,
  input logic [4:0]  base_idx,
  input logic [15:0] offset,
  input logic [63:0] mem_addr,
  input logic [7:0]  mem_be,
  input logic        mem_we,
  input logic        mem_re,
  input logic        fault,
  input logic        rd_valid,
  input logic        ld_valid,
  input logic        agen_misalign
);

  logic [63:0] off_sx;
  assign off_sx = {{48{offset[15]}}, offset};

  assert_fault_blocks_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!mem_we && !mem_re));

  assert_aligned_reaches_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !agen_misalign) |-> (mem_we || mem_re));

  assert_store_lane_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($countones(mem_be) == (32'd1 << req_size)));

  assert_load_lane_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> ($countones(mem_be) == (32'd1 << req_size)));

  assert_abs_base_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && base_idx == 5'd0) |-> (mem_addr[63:3] == off_sx[63:3]));

  assert_result_follows_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> ld_valid);

  assert_result_needs_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(rd_valid));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!mem_we && !mem_re && !fault));

endmodule

bind lsa_unit lsa_unit_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_size      (req_size),
  .base_idx      (base_idx),
  .offset        (offset),
  .mem_addr      (mem_addr),
  .mem_be        (mem_be),
  .mem_we        (mem_we),
  .mem_re        (mem_re),
  .fault         (fault),
  .rd_valid      (rd_valid),
  .ld_valid      (ld_valid),
  .agen_misalign (agen_misalign)
);

// File: tb/lsa_unit_test.sv
module lsa_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_unsigned = 1'b0, big_endian = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [4:0]  base_idx = 5'd0;
  logic [63:0] base_val = 64'd0;
  logic [15:0] offset = 16'd0;
  logic [63:0] st_data = 64'd0;
  logic        rd_valid = 1'b0;
  logic [63:0] rd_data = 64'd0;
  logic [63:0] mem_addr, mem_wdata, ld_result;
  logic [7:0]  mem_be;
  logic        mem_we, mem_re, fault, ld_valid;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  lsa_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .big_endian(big_endian),
    .base_idx(base_idx), .base_val(base_val), .offset(offset), .st_data(st_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata), .fault(fault),
    .ld_valid(ld_valid), .ld_result(ld_result)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_ea(logic [4:0] idx, logic [63:0] b, logic [15:0] o);
    logic [63:0] base;
    base = (idx == 5'd0) ? 64'd0 : b;
    return base + {{48{o[15]}}, o};
  endfunction

  // lane that value byte i occupies (R5, R6)
  function automatic int lane_of(int a, int n, int i, logic big);
    return big ? (a + n - 1 - i) : (a + i);
  endfunction

  task automatic store_case(input string tag, input logic [4:0] idx, input logic [63:0] b,
                            input logic [15:0] o, input logic [1:0] sz, input logic big,
                            input logic [63:0] d);
    logic [63:0] ea, exp_w;
    logic [7:0]  exp_be;
    int n, a;
    @(negedge clk);
    req_valid = 1; req_store = 1; req_size = sz; big_endian = big;
    base_idx = idx; base_val = b; offset = o; st_data = d;
    ea = exp_ea(idx, b, o);
    n = 1 << sz;
    a = int'(ea[2:0]);
    exp_be = 8'h00; exp_w = 64'd0;
    for (int i = 0; i < n; i++) begin
      int l;
      l = lane_of(a, n, i, big);
      exp_be[l] = 1'b1;
      exp_w[8*l +: 8] = d[8*i +: 8];
    end
    #1;
    if ((ea % 64'(n)) != 0) begin
      chk({tag, " R3 fault"}, 64'(fault), 64'd1);
      chk({tag, " R3 no write"}, 64'({mem_we, mem_re}), 64'd0);
    end else begin
      chk({tag, " R1 addr"}, mem_addr, {ea[63:3], 3'b000});
      chk({tag, " R4 we"}, 64'({mem_we, fault}), 64'b10);
      chk({tag, " R4 be"}, 64'(mem_be), 64'(exp_be));
      chk({tag, big ? " R6 data" : " R5 data"}, mem_wdata, exp_w);
    end
    @(negedge clk);
    req_valid = 0;
    #1;
    chk({tag, " R12 idle"}, 64'({mem_we, mem_re, fault}), 64'd0);
  endtask

  task automatic load_case(input string tag, input logic [4:0] idx, input logic [63:0] b,
                           input logic [15:0] o, input logic [1:0] sz, input logic big,
                           input logic uns, input logic [63:0] word);
    logic [63:0] ea, g, keep;
    logic [7:0]  exp_be;
    int n, a;
    @(negedge clk);
    req_valid = 1; req_store = 0; req_size = sz; big_endian = big; req_unsigned = uns;
    base_idx = idx; base_val = b; offset = o; st_data = 64'd0;
    ea = exp_ea(idx, b, o);
    n = 1 << sz;
    a = int'(ea[2:0]);
    exp_be = 8'h00; g = 64'd0;
    for (int i = 0; i < n; i++) begin
      int l;
      l = lane_of(a, n, i, big);
      exp_be[l] = 1'b1;
      g[8*i +: 8] = word[8*l +: 8];
    end
    keep = (n == 8) ? '1 : ((64'd1 << (8*n)) - 64'd1);
    if (!uns && g[8*n-1]) g = g | ~keep;
    #1;
    if ((ea % 64'(n)) != 0) begin
      chk({tag, " R3 fault"}, 64'(fault), 64'd1);
      chk({tag, " R3 no read"}, 64'({mem_we, mem_re}), 64'd0);
      @(negedge clk);
      req_valid = 0;
    end else begin
      chk({tag, " R7 re"}, 64'({mem_re, mem_we, fault}), 64'b100);
      chk({tag, " R7 be"}, 64'(mem_be), 64'(exp_be));
      @(negedge clk);
      // inputs change while data returns: context must hold
      req_valid = 0; big_endian = ~big; req_unsigned = ~uns; req_size = ~sz;
      rd_valid = 1; rd_data = word;
      #1;
      chk({tag, " R10 not early"}, 64'(ld_valid), 64'd0);
      @(negedge clk);
      rd_valid = 0; rd_data = 64'd0;
      #1;
      chk({tag, " R10 valid"}, 64'(ld_valid), 64'd1);
      chk({tag, uns ? " R9 zext" : " R8 sext"}, ld_result, g);
      @(negedge clk);
      #1;
      chk({tag, " R10 drop"}, 64'(ld_valid), 64'd0);
    end
  endtask

  initial begin
    #(4 * 200000);
    chk("watchdog", 64'd1, 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1;
    chk("R11 reset valid", 64'(ld_valid), 64'd0);
    chk("R11 reset result", ld_result, 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk("R12 idle after reset", 64'({mem_we, mem_re, fault}), 64'd0);

    // stores, both orders, several lane offsets
    store_case("st byte le",   5'd3, 64'h1000, 16'h0005, 2'd0, 1'b0, 64'h0123_4567_89AB_CDEF);
    store_case("st half le",   5'd3, 64'h1000, 16'h0006, 2'd1, 1'b0, 64'h0000_0000_0000_A1B2);
    store_case("st half be",   5'd3, 64'h1000, 16'h0002, 2'd1, 1'b1, 64'h0000_0000_0000_A1B2);
    store_case("st word le",   5'd7, 64'h2004, 16'h0000, 2'd2, 1'b0, 64'h0000_0000_1122_3344);
    store_case("st word be",   5'd7, 64'h2000, 16'h0004, 2'd2, 1'b1, 64'h0000_0000_1122_3344);
    store_case("st dbl be",    5'd9, 64'h3000, 16'h0008, 2'd3, 1'b1, 64'h0102_0304_0506_0708);
    store_case("st neg off",   5'd9, 64'h3000, 16'hFFF9, 2'd0, 1'b0, 64'h0000_0000_0000_005A);
    store_case("st abs R2",    5'd0, 64'hDEAD_BEEF_0000_1111, 16'h0103, 2'd0, 1'b1, 64'h77);
    store_case("st abs neg R2",5'd0, 64'hFFFF_0000_1234_5678, 16'hFF00, 2'd2, 1'b0, 64'hCAFE_F00D);
    // misaligned
    store_case("st half mis",  5'd3, 64'h1000, 16'h0003, 2'd1, 1'b0, 64'h1234);
    store_case("st word mis",  5'd3, 64'h1000, 16'h0006, 2'd2, 1'b1, 64'h1234);
    store_case("st dbl mis",   5'd3, 64'h1000, 16'h0004, 2'd3, 1'b0, 64'h1234);

    // loads
    load_case("ld byte s",     5'd2, 64'h4000, 16'h0003, 2'd0, 1'b0, 1'b0, 64'h0011_2233_8C55_6677);
    load_case("ld byte u",     5'd2, 64'h4000, 16'h0003, 2'd0, 1'b0, 1'b1, 64'h0011_2233_8C55_6677);
    load_case("ld half be s",  5'd2, 64'h4000, 16'h0006, 2'd1, 1'b1, 1'b0, 64'hF0E1_0000_0000_0000);
    load_case("ld half le u",  5'd2, 64'h4000, 16'h0002, 2'd1, 1'b0, 1'b1, 64'h0000_0000_9ABC_0000);
    load_case("ld word be s",  5'd2, 64'h4004, 16'h0000, 2'd2, 1'b1, 1'b0, 64'h8899_AABB_0000_0000);
    load_case("ld word le s+", 5'd2, 64'h4000, 16'h0000, 2'd2, 1'b0, 1'b0, 64'hFFFF_FFFF_7654_3210);
    load_case("ld dbl le",     5'd0, 64'h0,    16'h0010, 2'd3, 1'b0, 1'b0, 64'h8123_4567_89AB_CDEF);
    load_case("ld dbl be",     5'd4, 64'h5000, 16'hFFF8, 2'd3, 1'b1, 1'b1, 64'h8123_4567_89AB_CDEF);
    load_case("ld word mis",   5'd2, 64'h4000, 16'h0002, 2'd2, 1'b0, 1'b0, 64'h0);
    load_case("ld dbl mis",    5'd2, 64'h4000, 16'h0001, 2'd3, 1'b1, 1'b0, 64'h0);

    @(negedge clk);
    #1;
    chk("R10 quiet end", 64'(ld_valid), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule